// File: doc/BRIEF.md
# Speculative Load Taint Tracker

This block decides whether a speculative load may make its result visible before it is known to be on the correct path. It holds one taint bit for each physical register and a tainted flag for each in-flight instruction tag. When the load pipeline evaluates a load it has classified as unsafe, the tracker looks up the taint of the load's source registers and returns a ready-to-expose verdict in the same cycle. With tracking enabled, it also marks the load's destination registers and its instruction tag as tainted. Taint therefore spreads along dependence chains. A load whose inputs carry no taint may expose early even though it is still speculative.

A mode input selects between taint tracking and a conservative policy. Under the conservative policy, every unsafe load is held back. An error output flags an unsafe load that had already been declared ready. The reorder-buffer side presents retiring-visible instructions on a clear port. An instruction whose tag is tainted removes the taint from its destination registers once all older branches have resolved. A flush wipes the whole bitmap. A counter records how many untainted unsafe loads were released early and will need validation after fetch.

Top module: `spec_taint_tracker`

## Requirements
- R1: The policy register resets to conservative (0) and takes the value of `mode_i` one cycle later. 1 means taint tracking.
- R2: Under the conservative policy, a valid unsafe load gets `ld_ready_o`=0. It gets `ld_err_o`=1 exactly when `ld_was_ready_i`=1. It changes no taint bit and no counter.
- R3: Under tracking, a valid unsafe load sets the taint bit of each destination index whose valid bit is 1 from the next cycle on. It also sets the tainted flag of `ld_tag_i`.
- R4: `ld_src_taint_o` is the OR of the taint bits of the source indices whose valid bit is 1. Source indices with a valid bit of 0 are ignored.
- R5: Under tracking, a valid unsafe load gets `ld_ready_o` = NOT `ld_src_taint_o` and `ld_err_o`=0.
- R6: `vld_cnt_o` resets to 0. It increases by one in the cycle after a valid unsafe load is evaluated under tracking with untainted sources, `ld_was_ready_i`=0 and `ld_need_pf_i`=1. Otherwise it holds.
- R7: A valid safe load (`ld_unsafe_i`=0) gets `ld_ready_o`=1 and `ld_err_o`=0, and changes no state. With `ld_valid_i`=0, both outputs are 0.
- R8: A clear request clears the taint bits of its valid destination indices. It does so only when the tainted flag of `clr_tag_i` is set and `clr_br_resolved_i`=1.
- R9: Allocating a tag (`alloc_valid_i`) resets its tainted flag. A later clear request from that tag has no effect.
- R10: When a set and a clear hit the same register in one cycle, the register stays tainted. The source lookup in that cycle sees the bitmap from before the cycle's updates.
- R11: `flush_i` clears every taint bit in the next cycle and overrides sets made in the same cycle. It leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Policy select: 1 taint tracking, 0 conservative |
| flush_i | input | 1 | Pipeline flush, wipes the bitmap |
| alloc_valid_i | input | 1 | Instruction tag allocation |
| alloc_tag_i | input | TW | Allocated tag |
| ld_valid_i | input | 1 | Load evaluation request |
| ld_tag_i | input | TW | Tag of the evaluated load |
| ld_unsafe_i | input | 1 | Load classified as unsafe speculative |
| ld_was_ready_i | input | 1 | Load's previous ready-to-expose state |
| ld_need_pf_i | input | 1 | Load needs post-fetch validation |
| ld_src_vld_i | input | NSRC | Source index valid bits |
| ld_src_idx_i | input | NSRC*PW | Source physical register indices, index k in bits k*PW upward |
| ld_dst_vld_i | input | NDST | Destination index valid bits |
| ld_dst_idx_i | input | NDST*PW | Destination physical register indices, packed like the sources |
| ld_ready_o | output | 1 | Ready-to-expose verdict |
| ld_err_o | output | 1 | Unsafe load was already ready under the conservative policy |
| ld_src_taint_o | output | 1 | Source taint status |
| clr_valid_i | input | 1 | Reorder-buffer clear request |
| clr_tag_i | input | TW | Tag of the clearing instruction |
| clr_br_resolved_i | input | 1 | All older branches resolved |
| clr_dst_vld_i | input | NDST | Clear destination valid bits |
| clr_dst_idx_i | input | NDST*PW | Clear destination indices |
| vld_cnt_o | output | CNTW | Loads-to-validate counter |

## Verification
The load port and the clear port can act on the same physical register in one cycle. The bench first taints a register from one tag. In a later cycle it evaluates a second unsafe load that reads and rewrites that register, while the first tag clears it. The verdict in that cycle must reflect the old, tainted bitmap, and the register must remain tainted afterwards. A clear of the same register without a competing set must then empty the bit. The bench reads the bit back through a safe probe load's source-taint output.

// File: rtl/spec_taint_tracker.sv
module spec_taint_tracker #(
  parameter int NPREG = 128,
  parameter int NSRC  = 3,
  parameter int NDST  = 2,
  parameter int NTAG  = 64,
  parameter int CNTW  = 16,
  localparam int PW   = $clog2(NPREG),
  localparam int TW   = $clog2(NTAG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  input  logic [TW-1:0]     alloc_tag_i,
  input  logic              ld_valid_i,
  input  logic [TW-1:0]     ld_tag_i,
  input  logic              ld_unsafe_i,
  input  logic              ld_was_ready_i,
  input  logic              ld_need_pf_i,
  input  logic [NSRC-1:0]   ld_src_vld_i,
  input  logic [NSRC*PW-1:0] ld_src_idx_i,
  input  logic [NDST-1:0]   ld_dst_vld_i,
  input  logic [NDST*PW-1:0] ld_dst_idx_i,
  output logic              ld_ready_o,
  output logic              ld_err_o,
  output logic              ld_src_taint_o,
  input  logic              clr_valid_i,
  input  logic [TW-1:0]     clr_tag_i,
  input  logic              clr_br_resolved_i,
  input  logic [NDST-1:0]   clr_dst_vld_i,
  input  logic [NDST*PW-1:0] clr_dst_idx_i,
  output logic [CNTW-1:0]   vld_cnt_o
);

  logic             mode_q;
  logic [NPREG-1:0] taint_q, set_mask, clr_mask;
  logic [NTAG-1:0]  flag_q;
  logic             src_hit, unsafe_ld, track_ld, clr_go, cnt_inc;

  always_comb begin
    src_hit = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (ld_src_vld_i[s]) src_hit = src_hit | taint_q[ld_src_idx_i[s*PW +: PW]];
  end

  assign unsafe_ld      = ld_valid_i && ld_unsafe_i;
  assign track_ld       = unsafe_ld && mode_q;
  assign clr_go         = clr_valid_i && clr_br_resolved_i && flag_q[clr_tag_i];
  assign ld_src_taint_o = src_hit;
  assign ld_err_o       = unsafe_ld && !mode_q && ld_was_ready_i;
  assign ld_ready_o     = ld_valid_i && (!ld_unsafe_i || (mode_q && !src_hit));
  assign cnt_inc        = track_ld && !src_hit && !ld_was_ready_i && ld_need_pf_i;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int d = 0; d < NDST; d++) begin
      if (track_ld && ld_dst_vld_i[d]) set_mask[ld_dst_idx_i[d*PW +: PW]] = 1'b1;
      if (clr_go && clr_dst_vld_i[d])  clr_mask[clr_dst_idx_i[d*PW +: PW]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      taint_q   <= '0;
      flag_q    <= '0;
      vld_cnt_o <= '0;
    end else begin
      mode_q  <= mode_i;
      taint_q <= flush_i ? '0 : ((taint_q & ~clr_mask) | set_mask);
      if (alloc_valid_i) flag_q[alloc_tag_i] <= 1'b0;
      if (track_ld)      flag_q[ld_tag_i]    <= 1'b1;
      if (cnt_inc)       vld_cnt_o <= vld_cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/spec_taint_tracker_chk.sv
module spec_taint_tracker_chk #(
  parameter int CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_q,
  input logic            flush_i,
  input logic            ld_valid_i,
  input logic            ld_unsafe_i,
  input logic            ld_was_ready_i,
  input logic            ld_ready_o,
  input logic            ld_err_o,
  input logic            ld_src_taint_o,
  input logic [CNTW-1:0] vld_cnt_o
);

  AST_CONSERVATIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && ld_unsafe_i && !mode_q) |-> !ld_ready_o); // R2

  AST_ERR_ONLY_CONSERVATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_err_o |-> (!mode_q && ld_was_ready_i)); // R2

  AST_TRACK_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && ld_unsafe_i && mode_q) |-> (ld_ready_o != ld_src_taint_o)); // R5

  AST_SAFE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && !ld_unsafe_i) |-> (ld_ready_o && !ld_err_o)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vld_cnt_o == $past(vld_cnt_o)) || (vld_cnt_o == $past(vld_cnt_o) + 1'b1))); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !ld_src_taint_o); // R11

endmodule

bind spec_taint_tracker spec_taint_tracker_chk #(.CNTW(CNTW)) u_chk (.*);

// File: tb/sim_spec_taint_tracker.sv
module sim_spec_taint_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 7;
  localparam int TW = 6;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic mode_i = 0, flush_i = 0, alloc_valid_i = 0;
  logic [TW-1:0] alloc_tag_i = '0, ld_tag_i = '0, clr_tag_i = '0;
  logic ld_valid_i = 0, ld_unsafe_i = 0, ld_was_ready_i = 0, ld_need_pf_i = 0;
  logic [2:0] ld_src_vld_i = '0;
  logic [3*PW-1:0] ld_src_idx_i = '0;
  logic [1:0] ld_dst_vld_i = '0, clr_dst_vld_i = '0;
  logic [2*PW-1:0] ld_dst_idx_i = '0, clr_dst_idx_i = '0;
  logic clr_valid_i = 0, clr_br_resolved_i = 0;
  logic ld_ready_o, ld_err_o, ld_src_taint_o;
  logic [CW-1:0] vld_cnt_o;

  int checks = 0, failures = 0;
  logic done = 0;

  spec_taint_tracker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush_i = 0; alloc_valid_i = 0; ld_valid_i = 0; ld_unsafe_i = 0;
    ld_was_ready_i = 0; ld_need_pf_i = 0; ld_src_vld_i = '0; ld_dst_vld_i = '0;
    clr_valid_i = 0; clr_br_resolved_i = 0; clr_dst_vld_i = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle(); @(negedge clk);
  endtask

  task automatic load(input int tag, input bit unsafe, input bit wr, input bit pf,
                      input logic [2:0] sv, input int s0, input int s1, input int s2,
                      input logic [1:0] dv, input int d0, input int d1);
    ld_valid_i = 1; ld_tag_i = TW'(tag); ld_unsafe_i = unsafe;
    ld_was_ready_i = wr; ld_need_pf_i = pf; ld_src_vld_i = sv;
    ld_src_idx_i = {PW'(s2), PW'(s1), PW'(s0)};
    ld_dst_vld_i = dv; ld_dst_idx_i = {PW'(d1), PW'(d0)};
    #1;
  endtask

  task automatic clear(input int tag, input bit res, input logic [1:0] dv, input int d0, input int d1);
    clr_valid_i = 1; clr_tag_i = TW'(tag); clr_br_resolved_i = res;
    clr_dst_vld_i = dv; clr_dst_idx_i = {PW'(d1), PW'(d0)};
    #1;
  endtask

  task automatic probe(input string req, input int r, input bit exp);
    load(0, 0, 0, 0, 3'b001, r, 0, 0, 2'b00, 0, 0);
    chk(req, ld_src_taint_o, exp);
    ld_valid_i = 0; ld_src_vld_i = '0;
    #1;
  endtask

  task automatic t_reset();
    chk("R6 reset counter", vld_cnt_o, 0);
    probe("R11 reset bitmap", 5, 0);
    chk("R7 idle ready", ld_ready_o, 0);
    load(1, 1, 0, 1, 3'b000, 0, 0, 0, 2'b01, 5, 0);
    chk("R1 reset conservative ready", ld_ready_o, 0);
    chk("R2 no err when not ready", ld_err_o, 0);
    tick();
    probe("R2 no taint set", 5, 0);
    chk("R2 counter held", vld_cnt_o, 0);
  endtask

  task automatic t_conservative();
    load(1, 1, 1, 1, 3'b000, 0, 0, 0, 2'b00, 0, 0);
    chk("R2 err raised", ld_err_o, 1);
    chk("R2 ready forced low", ld_ready_o, 0);
    tick();
  endtask

  task automatic t_safe();
    load(2, 0, 0, 1, 3'b000, 0, 0, 0, 2'b01, 6, 0);
    chk("R7 safe ready", ld_ready_o, 1);
    chk("R7 safe no err", ld_err_o, 0);
    tick();
    probe("R7 safe no taint", 6, 0);
    chk("R7 safe counter", vld_cnt_o, 0);
  endtask

  task automatic t_mode_latency();
    mode_i = 1;
    load(1, 1, 1, 0, 3'b000, 0, 0, 0, 2'b00, 0, 0);
    chk("R1 mode one cycle late err", ld_err_o, 1);
    tick();
    load(1, 1, 1, 0, 3'b000, 0, 0, 0, 2'b00, 0, 0);
    chk("R1 tracking active no err", ld_err_o, 0);
    ld_valid_i = 0; #1;
  endtask

  task automatic t_track();
    load(3, 1, 0, 1, 3'b001, 1, 0, 0, 2'b11, 10, 11);
    chk("R5 clean src ready", ld_ready_o, 1);
    chk("R4 clean src", ld_src_taint_o, 0);
    tick();
    chk("R6 counter inc", vld_cnt_o, 1);
    probe("R3 dst0 tainted", 10, 1);
    probe("R3 dst1 tainted", 11, 1);
  endtask

  task automatic t_prop();
    load(4, 1, 0, 1, 3'b100, 10, 10, 11, 2'b01, 20, 0);
    chk("R4 tainted src2", ld_src_taint_o, 1);
    chk("R5 tainted not ready", ld_ready_o, 0);
    tick();
    chk("R6 no inc on taint", vld_cnt_o, 1);
    probe("R3 propagated", 20, 1);
    load(8, 1, 1, 1, 3'b000, 10, 11, 0, 2'b00, 0, 0);
    chk("R4 invalid src ignored", ld_src_taint_o, 0);
    chk("R5 ready with invalid src", ld_ready_o, 1);
    tick();
    chk("R6 no inc when was ready", vld_cnt_o, 1);
    load(8, 1, 0, 0, 3'b000, 0, 0, 0, 2'b00, 0, 0);
    tick();
    chk("R6 no inc without post fetch", vld_cnt_o, 1);
  endtask

  task automatic t_clear();
    clear(7, 1, 2'b01, 10, 0);
    tick();
    probe("R8 untainted tag no clear", 10, 1);
    clear(3, 0, 2'b01, 10, 0);
    tick();
    probe("R8 unresolved no clear", 10, 1);
    clear(3, 1, 2'b11, 10, 11);
    tick();
    probe("R8 cleared dst0", 10, 0);
    probe("R8 cleared dst1", 11, 0);
    alloc_valid_i = 1; alloc_tag_i = 4;
    tick();
    clear(4, 1, 2'b01, 20, 0);
    tick();
    probe("R9 realloc flag reset", 20, 1);
  endtask

  task automatic t_same();
    load(5, 1, 1, 0, 3'b000, 0, 0, 0, 2'b01, 30, 0);
    tick();
    probe("R3 reg30 tainted", 30, 1);
    load(6, 1, 1, 0, 3'b001, 30, 0, 0, 2'b01, 30, 0);
    clear(5, 1, 2'b01, 30, 0);
    chk("R10 lookup pre update", ld_ready_o, 0);
    tick();
    probe("R10 set wins", 30, 1);
    load(9, 1, 1, 0, 3'b001, 30, 0, 0, 2'b00, 0, 0);
    clear(5, 1, 2'b01, 30, 0);
    chk("R10 clear not yet seen", ld_src_taint_o, 1);
    tick();
    probe("R8 clear alone", 30, 0);
  endtask

  task automatic t_flush();
    flush_i = 1;
    load(9, 1, 0, 1, 3'b000, 0, 0, 0, 2'b01, 31, 0);
    tick();
    probe("R11 flush wiped", 20, 0);
    probe("R11 flush beats set", 31, 0);
    chk("R11 counter kept", vld_cnt_o, 2);
  endtask

  task automatic t_back();
    mode_i = 0;
    tick();
    load(1, 1, 0, 1, 3'b000, 0, 0, 0, 2'b00, 0, 0);
    chk("R1 back to conservative", ld_ready_o, 0);
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_conservative();
    t_safe();
    t_mode_latency();
    t_track();
    t_prop();
    t_clear();
    t_same();
    t_flush();
    t_back();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule